// File: doc/BRIEF.md
# Page Transfer Buffer with Shadow Restore

This block moves whole pages between a memory array whose reads are destructive and a 16-bit external data port. A page of 16K bits is handled as 64 groups of 256 bits, visited in ascending order. On a page read, each group is fetched from the array into a 256-bit transfer buffer and streamed out as sixteen 16-bit words, one per clock. A shadow register takes a copy of the group and writes it back to its array location while the words are still streaming, because fetching a group erases it. On a page write, sixteen incoming words fill the transfer buffer. The full group is then handed to the shadow register, which commits it to the array while the transfer buffer collects the next group.

The shadow register holds one group at a time. If its write-back has not finished when the next group needs it, the array-side ready flag drops and the sequencer waits. No group is ever overwritten. Refresh commands are accepted and have no effect, because the storage does not need refreshing. A small behavioural array model is part of the block. It clears a group when it is read and takes a configurable number of cycles to complete each write-back.

Top module: `page_shadow_buf`

## Requirements
- R1: While reset is held, and after it is released until the first command, dout_valid, wr_ready and page_done are 0, arr_ready is 1 and grp_idx is 0.
- R2: After cmd_write in idle, wr_ready goes high. Each word presented with din_valid while wr_ready is high is accepted. Words fill group positions 0..15 in order, with word k at bits 16k+15:16k, and groups fill 0..63 in order.
- R3: After cmd_read in idle, the block outputs 1024 words with dout_valid high. Group 0 comes first and words within a group rise from word 0 (bits 15:0). The 16 words of a group appear on 16 consecutive cycles.
- R4: Reading a group clears it in the array. The shadow register restores it, so a second read of the same page returns the same 1024 words as the first.
- R5: The restore of a group runs while that group is still streaming: arr_ready is low in at least one cycle that has dout_valid high.
- R6: While the shadow register is busy, no array read and no new shadow load take place. The stream pauses with dout_valid low and arr_ready low, and no data is lost.
- R7: During a page write, the transfer buffer accepts the next group while the previous group is being committed: wr_ready is high in at least one cycle that has arr_ready low.
- R8: cmd_refresh is ignored. In idle it starts nothing. During a page read it leaves the stream and its data unchanged.
- R9: grp_idx counts 0 to 63 and wraps to 0. page_done is a one-cycle pulse that appears only after the last group's write-back has finished (arr_ready high, grp_idx 63). grp_idx is 0 in the following cycle.
- R10: cmd_read or cmd_write that arrives while a page operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read | input | 1 | Start a page read (idle only) |
| cmd_write | input | 1 | Start a page write (idle only) |
| cmd_refresh | input | 1 | Refresh command, ignored |
| din | input | 16 | Write data word |
| din_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Transfer buffer accepts write words |
| dout | output | 16 | Read data word |
| dout_valid | output | 1 | Read word present |
| grp_idx | output | 6 | Group currently transferred |
| arr_ready | output | 1 | Shadow register free (no write-back pending) |
| page_done | output | 1 | One-cycle pulse at the end of a page |

## Verification
Five page patterns are written and then read back twice: a group/word counter, all ones, a group-salted 0xA5A5 value, a walking one mixed with the group number, and an inverted counter. The all-ones page separates a real restore from the zeros that a lost write-back would leave. The counter patterns expose swapped words or groups. Some runs add refresh pulses or stray start commands during a transfer, to show that neither disturbs the stream. The pauses and overlaps seen on arr_ready show that restore runs in parallel with transfers and that the stall is honoured.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_RD_STREAM,
    ST_WR_FILL,
    ST_WR_HAND,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/pgb_seq.sv
module pgb_seq
  import pgb_pkg::*;
#(
  parameter int unsigned WORDS  = 16,
  parameter int unsigned GROUPS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_read,
  input  logic                      cmd_write,
  input  logic                      cmd_refresh,
  input  logic                      din_valid,
  input  logic                      sh_busy,
  output logic                      arr_rd,
  output logic                      xbuf_cap,
  output logic                      xbuf_wr,
  output logic                      sh_load,
  output logic [$clog2(WORDS)-1:0]  beat,
  output logic [$clog2(GROUPS)-1:0] grp,
  output logic                      dout_valid,
  output logic                      wr_ready,
  output logic                      page_done
);
  localparam int unsigned BW = $clog2(WORDS);
  localparam int unsigned GW = $clog2(GROUPS);
  localparam logic [BW-1:0] LAST_BEAT = BW'(WORDS - 1);
  localparam logic [GW-1:0] LAST_GRP  = GW'(GROUPS - 1);

  seq_state_e      state_q, state_n;
  logic [BW-1:0]   beat_q, beat_n;
  logic [GW-1:0]   grp_q, grp_n;

  always_comb begin
    state_n    = state_q;
    beat_n     = beat_q;
    grp_n      = grp_q;
    arr_rd     = 1'b0;
    xbuf_cap   = 1'b0;
    xbuf_wr    = 1'b0;
    sh_load    = 1'b0;
    dout_valid = 1'b0;
    wr_ready   = 1'b0;
    page_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_read) begin
          state_n = ST_RD_REQ;
          beat_n  = '0;
          grp_n   = '0;
        end else if (cmd_write) begin
          state_n = ST_WR_FILL;
          beat_n  = '0;
          grp_n   = '0;
        end else if (cmd_refresh) begin
          state_n = ST_IDLE;  // acknowledged, nothing to do
        end
      end
      ST_RD_REQ: begin
        if (!sh_busy) begin
          arr_rd  = 1'b1;
          state_n = ST_RD_CAP;
        end
      end
      ST_RD_CAP: begin
        xbuf_cap = 1'b1;
        beat_n   = '0;
        state_n  = ST_RD_STREAM;
      end
      ST_RD_STREAM: begin
        dout_valid = 1'b1;
        sh_load    = (beat_q == '0);
        beat_n     = beat_q + BW'(1);
        if (beat_q == LAST_BEAT) begin
          if (grp_q == LAST_GRP) begin
            state_n = ST_FINISH;
          end else begin
            grp_n   = grp_q + GW'(1);
            state_n = ST_RD_REQ;
          end
        end
      end
      ST_WR_FILL: begin
        wr_ready = 1'b1;
        if (din_valid) begin
          xbuf_wr = 1'b1;
          beat_n  = beat_q + BW'(1);
          if (beat_q == LAST_BEAT) state_n = ST_WR_HAND;
        end
      end
      ST_WR_HAND: begin
        if (!sh_busy) begin
          sh_load = 1'b1;
          beat_n  = '0;
          if (grp_q == LAST_GRP) begin
            state_n = ST_FINISH;
          end else begin
            grp_n   = grp_q + GW'(1);
            state_n = ST_WR_FILL;
          end
        end
      end
      ST_FINISH: begin
        if (!sh_busy) begin
          page_done = 1'b1;
          grp_n     = '0;
          state_n   = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      grp_q   <= '0;
    end else begin
      state_q <= state_n;
      beat_q  <= beat_n;
      grp_q   <= grp_n;
    end
  end

  assign beat = beat_q;
  assign grp  = grp_q;

  // R3
  stream_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && beat_q != LAST_BEAT) |=> dout_valid);

  // R9
  grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_q != $past(grp_q)) |-> ((grp_q == $past(grp_q) + GW'(1)) || (grp_q == '0)));

  // R9
  done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> (grp_q == '0 && state_q == ST_IDLE));

  // R8
  refresh_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd_refresh && !cmd_read && !cmd_write) |=> (state_q == ST_IDLE));

  // R10
  cmd_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_FILL && cmd_read) |=> (state_q == ST_WR_FILL || state_q == ST_WR_HAND));
endmodule

// File: rtl/pgb_xbuf.sv
module pgb_xbuf #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap,
  input  logic [WORD_W*WORDS-1:0]   cap_data,
  input  logic                      wr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [$clog2(WORDS)-1:0]  beat,
  output logic [WORD_W*WORDS-1:0]   buf_data,
  output logic [WORD_W-1:0]         word_out
);
  localparam int unsigned BW = $clog2(WORDS);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] w_q;
    logic              w_en;
    logic [WORD_W-1:0] w_n;

    always_comb begin
      w_en = cap || (wr && beat == BW'(i));
      w_n  = cap ? cap_data[i*WORD_W +: WORD_W] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= w_n;
    end

    assign buf_data[i*WORD_W +: WORD_W] = w_q;
  end

  assign word_out = buf_data[32'(beat)*WORD_W +: WORD_W];
endmodule

// File: rtl/pgb_shadow.sv
module pgb_shadow #(
  parameter int unsigned GRP_W  = 256,
  parameter int unsigned GW     = 6,
  parameter int unsigned WB_CYC = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GRP_W-1:0] load_data,
  input  logic [GW-1:0]    load_addr,
  output logic             busy,
  output logic             wr_en,
  output logic [GW-1:0]    wr_addr,
  output logic [GRP_W-1:0] wr_data
);
  localparam int unsigned CW = $clog2(WB_CYC + 1);

  logic             busy_q, busy_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [GW-1:0]    addr_q;
  logic [GRP_W-1:0] data_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = CW'(WB_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      data_q <= load_data;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q && (cnt_q == '0);
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R6
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  // R4
  commit_before_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(wr_en));
endmodule

// File: rtl/pgb_array.sv
module pgb_array #(
  parameter int unsigned GRP_W  = 256,
  parameter int unsigned GROUPS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd,
  input  logic [$clog2(GROUPS)-1:0] rd_addr,
  output logic [GRP_W-1:0]          rd_data,
  input  logic                      wr,
  input  logic [$clog2(GROUPS)-1:0] wr_addr,
  input  logic [GRP_W-1:0]          wr_data
);
  logic [GRP_W-1:0] mem_q [GROUPS];
  logic [GRP_W-1:0] rd_q;

  // behavioural storage: a read hands out the group and leaves zeros behind
  always_ff @(posedge clk) begin
    if (rd) begin
      rd_q           <= mem_q[rd_addr];
      mem_q[rd_addr] <= '0;
    end
    if (wr) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = rd_q;

  // R4
  rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> (rd_addr != wr_addr));
endmodule

// File: rtl/page_shadow_buf.sv
module page_shadow_buf #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 16,
  parameter int unsigned GROUPS = 64,
  parameter int unsigned WB_CYC = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_read,
  input  logic                      cmd_write,
  input  logic                      cmd_refresh,
  input  logic [WORD_W-1:0]         din,
  input  logic                      din_valid,
  output logic                      wr_ready,
  output logic [WORD_W-1:0]         dout,
  output logic                      dout_valid,
  output logic [$clog2(GROUPS)-1:0] grp_idx,
  output logic                      arr_ready,
  output logic                      page_done
);
  localparam int unsigned GRP_W = WORD_W * WORDS;
  localparam int unsigned GW    = $clog2(GROUPS);
  localparam int unsigned BW    = $clog2(WORDS);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             arr_rd, xbuf_cap, xbuf_wr, sh_load, sh_busy, sh_wr;
  logic [BW-1:0]    beat;
  logic [GW-1:0]    grp, sh_addr;
  logic [GRP_W-1:0] arr_rdata, buf_data, sh_data;

  pgb_seq #(.WORDS(WORDS), .GROUPS(GROUPS)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_refresh(cmd_refresh),
    .din_valid(din_valid), .sh_busy(sh_busy),
    .arr_rd(arr_rd), .xbuf_cap(xbuf_cap), .xbuf_wr(xbuf_wr), .sh_load(sh_load),
    .beat(beat), .grp(grp),
    .dout_valid(dout_valid), .wr_ready(wr_ready), .page_done(page_done)
  );

  pgb_xbuf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_xbuf (
    .clk(clk), .rst_n(rst_n_s),
    .cap(xbuf_cap), .cap_data(arr_rdata),
    .wr(xbuf_wr), .wr_data(din), .beat(beat),
    .buf_data(buf_data), .word_out(dout)
  );

  pgb_shadow #(.GRP_W(GRP_W), .GW(GW), .WB_CYC(WB_CYC)) u_shadow (
    .clk(clk), .rst_n(rst_n_s),
    .load(sh_load), .load_data(buf_data), .load_addr(grp),
    .busy(sh_busy), .wr_en(sh_wr), .wr_addr(sh_addr), .wr_data(sh_data)
  );

  pgb_array #(.GRP_W(GRP_W), .GROUPS(GROUPS)) u_array (
    .clk(clk), .rst_n(rst_n_s),
    .rd(arr_rd), .rd_addr(grp), .rd_data(arr_rdata),
    .wr(sh_wr), .wr_addr(sh_addr), .wr_data(sh_data)
  );

  assign grp_idx   = grp;
  assign arr_ready = !sh_busy;

  // R6
  read_vs_restore_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    arr_rd |-> !sh_busy);

  // R5
  restore_target_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dout_valid && sh_busy) |-> (sh_addr == grp));
endmodule

// File: tb/test_page_shadow_buf.sv
module test_page_shadow_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_read, cmd_write, cmd_refresh;
  logic [15:0] din;
  logic        din_valid;
  logic        wr_ready;
  logic [15:0] dout;
  logic        dout_valid;
  logic [5:0]  grp_idx;
  logic        arr_ready;
  logic        page_done;

  int errors = 0;
  int checks = 0;
  bit fin    = 1'b0;

  always #2.5 clk = ~clk;

  page_shadow_buf i_page_shadow_buf (
    .clk(clk), .rst_n(rst_n),
    .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_refresh(cmd_refresh),
    .din(din), .din_valid(din_valid), .wr_ready(wr_ready),
    .dout(dout), .dout_valid(dout_valid), .grp_idx(grp_idx),
    .arr_ready(arr_ready), .page_done(page_done)
  );

  // pattern, inject refresh during read, inject stray start commands
  localparam int NVEC = 5;
  localparam int VEC_PAT [NVEC] = '{0, 1, 2, 3, 4};
  localparam bit VEC_REF [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam bit VEC_CMD [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  function automatic logic [15:0] exp_word(input int pat, input int g, input int w);
    case (pat)
      0:       return 16'(g * 16 + w);
      1:       return 16'hFFFF;
      2:       return 16'hA5A5 ^ 16'(g * 257);
      3:       return 16'(1 << w) ^ 16'(g << 9);
      default: return ~16'(g * 16 + w) ^ 16'h0F0F;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int c = 0; c < 400 && !seen; c++) begin
      if (page_done) begin
        seen = 1'b1;
        chk(arr_ready == 1'b1, req, "arr_ready at page_done", arr_ready, 1);
        chk(grp_idx == 6'd63, req, "grp_idx at page_done", grp_idx, 63);
      end
      @(negedge clk);
    end
    chk(seen, req, "page_done seen", seen, 1);
    chk(page_done == 1'b0 && grp_idx == 6'd0, req, "pulse ends and index wraps",
        {page_done, grp_idx}, 0);
  endtask

  task automatic write_page(input int pat, input bit stray);
    int  k = 0;
    int  guard = 0;
    bit  overlap = 1'b0;
    cmd_write = 1'b1;
    @(negedge clk);
    cmd_write = 1'b0;
    while (k < 1024 && guard < 20000) begin
      cmd_read = stray && (guard % 29 == 5);  // R10 stray start while busy
      if (wr_ready) begin
        din       = exp_word(pat, k / 16, k % 16);
        din_valid = 1'b1;
        if (!arr_ready) overlap = 1'b1;
        k++;
      end else begin
        din_valid = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    din_valid = 1'b0;
    cmd_read  = 1'b0;
    chk(k == 1024, "R2", "write words accepted", k, 1024);
    chk(overlap, "R7", "fill overlaps commit", overlap, 1);
    chk(wr_ready == 1'b0 && dout_valid == 1'b0, "R10", "no read started during write",
        {wr_ready, dout_valid}, 0);
    wait_done("R9");
  endtask

  task automatic read_page(input int pat, input bit inj_ref, input bit stray, input string req);
    int k = 0, run = 0, guard = 0, bad_runs = 0, mism = 0;
    bit ov = 1'b0, stall = 1'b0, done = 1'b0, wr_seen = 1'b0;
    logic [15:0] first_act = '0, first_exp = '0;
    cmd_read = 1'b1;
    @(negedge clk);
    cmd_read = 1'b0;
    while (!done && guard < 20000) begin
      cmd_refresh = inj_ref && (guard % 23 == 7);
      cmd_write   = stray && (guard % 31 == 3);
      if (dout_valid) begin
        if (k < 1024 && dout !== exp_word(pat, k / 16, k % 16)) begin
          if (mism == 0) begin
            first_act = dout;
            first_exp = exp_word(pat, k / 16, k % 16);
          end
          mism++;
        end
        if (!arr_ready) ov = 1'b1;
        run++;
        k++;
      end else begin
        if (run != 0 && run != 16) bad_runs++;
        run = 0;
        if (k > 0 && k < 1024 && !arr_ready) stall = 1'b1;
      end
      if (wr_ready) wr_seen = 1'b1;
      if (page_done) done = 1'b1;
      @(negedge clk);
      guard++;
    end
    cmd_refresh = 1'b0;
    cmd_write   = 1'b0;
    chk(mism == 0, req, "read data order/value", first_act, first_exp);
    chk(k == 1024, "R3", "words streamed", k, 1024);
    chk(bad_runs == 0, "R3", "16-beat runs", bad_runs, 0);
    chk(ov, "R5", "restore overlaps stream", ov, 1);
    chk(stall, "R6", "stall with arr_ready low", stall, 1);
    chk(done, "R9", "page_done after read", done, 1);
    if (stray) chk(!wr_seen, "R10", "stray write ignored during read", wr_seen, 0);
    chk(page_done == 1'b0 && grp_idx == 6'd0, "R9", "wrap after read", {page_done, grp_idx}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_read = 1'b0; cmd_write = 1'b0; cmd_refresh = 1'b0;
    din = '0; din_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(dout_valid == 0 && wr_ready == 0 && page_done == 0 && arr_ready == 1 && grp_idx == 0,
        "R1", "outputs in reset", {dout_valid, wr_ready, page_done, arr_ready, grp_idx}, 8'h08 << 3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_valid == 0 && wr_ready == 0 && page_done == 0 && arr_ready == 1 && grp_idx == 0,
        "R1", "outputs after reset", {dout_valid, wr_ready, page_done, arr_ready, grp_idx}, 8'h08 << 3);

    // R8 refresh in idle starts nothing
    cmd_refresh = 1'b1;
    @(negedge clk);
    cmd_refresh = 1'b0;
    for (int c = 0; c < 6; c++) begin
      chk(dout_valid == 0 && wr_ready == 0 && page_done == 0 && grp_idx == 0,
          "R8", "refresh in idle", {dout_valid, wr_ready, page_done}, 0);
      @(negedge clk);
    end

    for (int v = 0; v < NVEC; v++) begin
      write_page(VEC_PAT[v], VEC_CMD[v]);
      read_page(VEC_PAT[v], VEC_REF[v], VEC_CMD[v], VEC_REF[v] ? "R8" : "R3");
      read_page(VEC_PAT[v], 1'b0, 1'b0, "R4");
      repeat (3) @(negedge clk);
    end

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule